// File: doc/BRIEF.md
# Timer Compare Channel with PWM

This block is a free-running counter with a programmable reload value and a single compare channel that drives one reference output. The counter can run edge-aligned, either counting up from zero to the reload value or down from the reload value to zero. It can also run center-aligned, bouncing between zero and the reload value. Each wrap or turnaround raises a one-cycle update pulse.

The compare channel forms its reference level from the counter, the compare value and the current counting direction. It supports eight behaviours: hold, set on match, clear on match, toggle on match, forced low, forced high and two complementary PWM shapes. A polarity bit inverts the reference before it leaves the block.

In center-aligned operation one PWM period covers a full up sweep and a full down sweep. Software therefore programs the reload for twice the wanted PWM rate. With up-counting, a compare value of zero gives 0% duty and a compare value of the reload plus one gives 100% duty.

Top module: `tmr_pwm_channel`

## Requirements
- R1: While reset is high, the counter clears to 0 with the direction set to up, and the update pulse is low. The internal reference clears to inactive, so ref_o equals pol_i.
- R2: While en_i is low, the counter value and direction hold, no update pulse is produced, and no match event occurs.
- R3: Counting mode 0 (and the reserved code 3) counts up. When the counter is at or above the reload value, it wraps to 0 on the next enabled cycle. The update pulse is high in the cycle that shows the wrapped value, so it appears once every reload+1 enabled cycles.
- R4: Counting mode 1 counts down. From 0 it reloads the reload value and raises the update pulse.
- R5: Counting mode 2 counts up to the reload value and then down to 0, with a period of 2×reload cycles. An update pulse marks each turnaround.
- R6: In compare mode 6 (PWM 1), the reference is active when the counter is below the compare value while counting up, and active when it is at or below the compare value while counting down. The reference register takes the level computed from the counter value of the previous cycle. With up-counting, a compare value of 0 gives 0% duty and a compare value of reload+1 gives 100% duty.
- R7: Compare mode 7 (PWM 2) yields the inverse of PWM 1 in every counting direction.
- R8: Compare mode 1 sets the reference active on a match event, where the counter equals the compare value while enabled. Compare mode 2 clears it on a match event. Between match events the reference holds.
- R9: Compare mode 3 inverts the reference once per match event. There is no toggling while the counter is stopped.
- R10: Compare mode 4 forces the reference inactive and mode 5 forces it active, from the next clock edge on.
- R11: Compare mode 0 (frozen) leaves the reference unchanged, whatever the counter and compare values are.
- R12: pol_i = 1 inverts the reference at ref_o. pol_i = 0 passes it through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Counter enable |
| reload_i | input | CNT_W | Reload (top) value |
| cmp_i | input | CNT_W | Compare value |
| cnt_mode_i | input | 2 | Counting mode: 0 edge up, 1 edge down, 2 center, 3 as 0 |
| oc_mode_i | input | 3 | Compare mode code 0..7 |
| pol_i | input | 1 | Output inversion |
| ref_o | output | 1 | Reference output after polarity |
| upd_o | output | 1 | Update event pulse |

## Verification
The bench builds the block with its default 16-bit counter width. It uses small reload values (0, 4, 5 and 9), so several complete periods of every counting mode fit inside a 20-cycle observation window. High-cycle and update-pulse counts over that window can then be predicted by hand. The reload value of 0 brings the degenerate wrap-every-cycle case within reach. A compare value of reload+1 reaches the 100% duty end of the PWM range.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CM_EDGE_UP = 2'd0,
        CM_EDGE_DN = 2'd1,
        CM_CENTER  = 2'd2,
        CM_RSVD    = 2'd3
    } cnt_mode_e;

    typedef enum logic [2:0] {
        OC_FROZEN   = 3'd0,
        OC_SET      = 3'd1,
        OC_CLR      = 3'd2,
        OC_TOGGLE   = 3'd3,
        OC_FORCE_LO = 3'd4,
        OC_FORCE_HI = 3'd5,
        OC_PWM1     = 3'd6,
        OC_PWM2     = 3'd7
    } oc_mode_e;

    // Status the counter hands to the compare stage
    typedef struct packed {
        logic down;   // effective direction this cycle
        logic turn;   // counter sits at a wrap / turnaround point
    } cnt_stat_t;

    function automatic logic fixed_down(cnt_mode_e m);
        return (m == CM_EDGE_DN);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] reload_i,
    input  cnt_mode_e        mode_i,
    output logic [CNT_W-1:0] cnt_o,
    output cnt_stat_t        stat_o,
    output logic             upd_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dn_q, dn_d;
    logic             turn;
    logic             upd_q;

    always_comb begin
        cnt_d = cnt_q;
        dn_d  = dn_q;
        turn  = 1'b0;
        case (mode_i)
            CM_EDGE_DN: begin
                dn_d = 1'b1;
                if (cnt_q == ZERO) begin
                    cnt_d = reload_i;
                    turn  = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            CM_CENTER: begin
                if (!dn_q) begin
                    if (cnt_q >= reload_i) begin
                        turn  = 1'b1;
                        dn_d  = 1'b1;
                        cnt_d = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end else begin
                    if (cnt_q == ZERO) begin
                        turn  = 1'b1;
                        dn_d  = 1'b0;
                        cnt_d = (reload_i == ZERO) ? ZERO : ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            default: begin
                dn_d = 1'b0;
                if (cnt_q >= reload_i) begin
                    cnt_d = ZERO;
                    turn  = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= ZERO;
            dn_q  <= 1'b0;
            upd_q <= 1'b0;
        end else if (en_i) begin
            cnt_q <= cnt_d;
            dn_q  <= dn_d;
            upd_q <= turn;
        end else begin
            upd_q <= 1'b0;
        end
    end

    assign cnt_o       = cnt_q;
    assign upd_o       = upd_q;
    assign stat_o.down = fixed_down(mode_i) | ((mode_i == CM_CENTER) & dn_q);
    assign stat_o.turn = turn;

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             down_i,
    input  oc_mode_e         mode_i,
    input  logic             pol_i,
    output logic             ref_o
);
    logic ref_q, ref_d;
    logic hit;
    logic pwm_a;

    // a match only counts while the counter is running
    assign hit   = en_i && (cnt_i == cmp_i);
    assign pwm_a = down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);

    always_comb begin
        ref_d = ref_q;
        case (mode_i)
            OC_FROZEN:   ref_d = ref_q;
            OC_SET:      if (hit) ref_d = 1'b1;
            OC_CLR:      if (hit) ref_d = 1'b0;
            OC_TOGGLE:   if (hit) ref_d = ~ref_q;
            OC_FORCE_LO: ref_d = 1'b0;
            OC_FORCE_HI: ref_d = 1'b1;
            OC_PWM1:     ref_d = pwm_a;
            OC_PWM2:     ref_d = ~pwm_a;
            default:     ref_d = ref_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ref_q <= 1'b0;
        else       ref_q <= ref_d;
    end

    assign ref_o = ref_q ^ pol_i;

endmodule

// File: rtl/tmr_pwm_channel.sv
module tmr_pwm_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [1:0]       cnt_mode_i,
    input  logic [2:0]       oc_mode_i,
    input  logic             pol_i,
    output logic             ref_o,
    output logic             upd_o
);
    logic [CNT_W-1:0] cnt_w;
    cnt_stat_t        stat_w;
    cnt_mode_e        cmode;
    oc_mode_e         omode;

    assign cmode = cnt_mode_e'(cnt_mode_i);
    assign omode = oc_mode_e'(oc_mode_i);

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .reload_i (reload_i),
        .mode_i   (cmode),
        .cnt_o    (cnt_w),
        .stat_o   (stat_w),
        .upd_o    (upd_o)
    );

    tmr_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .cnt_i  (cnt_w),
        .cmp_i  (cmp_i),
        .down_i (stat_w.down),
        .mode_i (omode),
        .pol_i  (pol_i),
        .ref_o  (ref_o)
    );

endmodule

// File: rtl/tmr_pwm_chk.sv
module tmr_pwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             en_i,
    input logic [CNT_W-1:0] reload_i,
    input logic [1:0]       cnt_mode_i,
    input logic [2:0]       oc_mode_i,
    input logic             pol_i,
    input logic             ref_o,
    input logic             upd_o,
    input logic [CNT_W-1:0] cnt_i
);
    // R2
    hold_when_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(en_i)) |-> ($stable(cnt_i) && !upd_o));

    // R2
    upd_needs_en_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_o |-> $past(en_i));

    // R3
    up_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(en_i) && ($past(cnt_mode_i) == 2'd0)
         && ($past(cnt_i) >= $past(reload_i))) |-> ((cnt_i == '0) && upd_o));

    // R4
    down_reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(en_i) && ($past(cnt_mode_i) == 2'd1)
         && ($past(cnt_i) == '0)) |-> ((cnt_i == $past(reload_i)) && upd_o));

    // R10
    force_hi_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && ($past(oc_mode_i) == 3'd5)) |-> (ref_o == !pol_i));

    // R10
    force_lo_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && ($past(oc_mode_i) == 3'd4)) |-> (ref_o == pol_i));

    // R11
    frozen_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && ($past(oc_mode_i) == 3'd0) && $stable(pol_i)) |-> $stable(ref_o));

endmodule

bind tmr_pwm_channel tmr_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .reload_i   (reload_i),
    .cnt_mode_i (cnt_mode_i),
    .oc_mode_i  (oc_mode_i),
    .pol_i      (pol_i),
    .ref_o      (ref_o),
    .upd_o      (upd_o),
    .cnt_i      (cnt_w)
);

// File: tb/test_tmr_pwm_channel.sv
`timescale 1ns/1ps
module test_tmr_pwm_channel;

    localparam int W   = 16;
    localparam int WIN = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] rld = '0;
    logic [W-1:0] cmpv = '0;
    logic [1:0]   cm = 2'd0;
    logic [2:0]   om = 3'd0;
    logic         pol = 1'b0;
    logic         ref_o;
    logic         upd_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    tmr_pwm_channel #(.CNT_W(W)) i_tmr_pwm_channel (
        .clk_i(clk), .rst_i(rst), .en_i(en), .reload_i(rld), .cmp_i(cmpv),
        .cnt_mode_i(cm), .oc_mode_i(om), .pol_i(pol), .ref_o(ref_o), .upd_o(upd_o)
    );

    typedef struct packed {
        logic [1:0]  cm;
        logic [2:0]  om;
        logic        pol;
        logic [15:0] rld;
        logic [15:0] cmpv;
        logic [7:0]  hi;
        logic [7:0]  up;
    } vec_t;

    localparam int NV = 14;
    // expected high cycles and update pulses over a 20-cycle window after reset
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd6, 1'b0, 16'd9,  16'd3,  8'd6,  8'd2},  // R3 R6
        '{2'd0, 3'd6, 1'b0, 16'd9,  16'd0,  8'd0,  8'd2},  // R6 0% duty
        '{2'd0, 3'd6, 1'b0, 16'd9,  16'd10, 8'd20, 8'd2},  // R6 100% duty
        '{2'd0, 3'd7, 1'b0, 16'd9,  16'd3,  8'd14, 8'd2},  // R7
        '{2'd0, 3'd6, 1'b1, 16'd9,  16'd3,  8'd14, 8'd2},  // R12
        '{2'd1, 3'd6, 1'b0, 16'd9,  16'd3,  8'd8,  8'd2},  // R4 R6
        '{2'd2, 3'd6, 1'b0, 16'd5,  16'd2,  8'd8,  8'd3},  // R5 R6
        '{2'd2, 3'd7, 1'b0, 16'd5,  16'd2,  8'd12, 8'd3},  // R5 R7
        '{2'd0, 3'd3, 1'b0, 16'd4,  16'd2,  8'd10, 8'd4},  // R9
        '{2'd0, 3'd1, 1'b0, 16'd4,  16'd2,  8'd18, 8'd4},  // R8
        '{2'd0, 3'd5, 1'b0, 16'd9,  16'd3,  8'd20, 8'd2},  // R10
        '{2'd0, 3'd4, 1'b1, 16'd9,  16'd3,  8'd20, 8'd2},  // R10 R12
        '{2'd0, 3'd0, 1'b0, 16'd4,  16'd2,  8'd0,  8'd4},  // R11
        '{2'd1, 3'd7, 1'b0, 16'd9,  16'd3,  8'd12, 8'd2}   // R4 R7
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R3/R6";  1: return "R6";     2: return "R6";
            3: return "R7";     4: return "R12";    5: return "R4/R6";
            6: return "R5/R6";  7: return "R5/R7";  8: return "R9";
            9: return "R8";     10: return "R10";   11: return "R10/R12";
            12: return "R11";   default: return "R4/R7";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start(logic [1:0] c, logic [2:0] o, logic p, int r, int k);
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        cm = c; om = o; pol = p; rld = W'(r); cmpv = W'(k);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0; en = 1'b1;
    endtask

    task automatic run(int n, output int hi, output int up);
        hi = 0; up = 0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
            hi += int'(ref_o);
            up += int'(upd_o);
        end
    endtask

    initial begin
        int hi, up;
        // R1 reset state, both polarities
        rst = 1'b1; pol = 1'b0; om = 3'd5;
        @(posedge clk); @(negedge clk);
        chk("R1 ref", int'(ref_o), 0);
        chk("R1 upd", int'(upd_o), 0);
        pol = 1'b1; #1;
        chk("R1 ref pol", int'(ref_o), 1);

        for (int i = 0; i < NV; i++) begin
            start(VEC[i].cm, VEC[i].om, VEC[i].pol, int'(VEC[i].rld), int'(VEC[i].cmpv));
            run(WIN, hi, up);
            chk({vtag(i), " high"}, hi, int'(VEC[i].hi));
            chk({vtag(i), " upd"}, up, int'(VEC[i].up));
        end

        // R2: stop after two cycles (counter at 2), PWM1 cmp 2 -> ref low, no pulses
        start(2'd0, 3'd6, 1'b0, 3, 2);
        run(2, hi, up);
        en = 1'b0;
        run(12, hi, up);
        chk("R2 stopped high", hi, 0);
        chk("R2 stopped upd", up, 0);
        en = 1'b1;
        run(4, hi, up);
        chk("R2 resumed upd", up, 1);

        // R8 R11: set, freeze, then clear
        start(2'd0, 3'd1, 1'b0, 4, 2);
        run(6, hi, up);
        chk("R8 set", int'(ref_o), 1);
        om = 3'd0;
        run(15, hi, up);
        chk("R11 frozen", hi, 15);
        om = 3'd2;
        run(10, hi, up);
        chk("R8 clear", int'(ref_o), 0);

        // R9: counter stopped on the compare value, toggle must not run
        start(2'd0, 3'd3, 1'b0, 9, 0);
        en = 1'b0;
        run(10, hi, up);
        chk("R9 stopped toggle", hi, 0);

        // R3 R6: reload 0 wraps every cycle, cmp 1 is full duty
        start(2'd0, 3'd6, 1'b0, 0, 1);
        run(10, hi, up);
        chk("R3 reload0 upd", up, 10);
        chk("R6 reload0 full", hi, 10);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule